// File: doc/BRIEF.md
# Pseudo-Random Translation Entry Picker

This block supplies a replacement slot for a translation lookaside buffer. Each accepted request advances a 32-bit linear congruential state. The upper half of the new state is then folded into a window. The window starts at a programmable lower boundary (the count of locked, never-replaced slots) and ends at the last implemented slot. The locked slots below the boundary are therefore never chosen, and the picked slot never reaches the slot count.

The fold is a modulo by the window width. A small serial remainder unit computes it, one dividend bit per clock, so a result appears a fixed number of cycles after the request is accepted. The block samples the slot count and the boundary when it accepts a request. New requests are ignored until the result has been delivered. If the boundary is at or above the slot count, the window is empty. The block then reports the last slot and still advances its state.

Top module: `tlb_rand_idx`

## Requirements
- R1: Each accepted request replaces the state S with (S * 314159 + 1) modulo 2^32.
- R2: Reset (rst_n low, asynchronous) clears the state to zero, idx_o to 0 and idx_vld_o to 0, so the first result after reset is computed from state 1.
- R3: When wired_i < entries_i at acceptance, the result is ((S >> 16) mod (entries_i - wired_i)) + wired_i, where S is the state after the step.
- R4: When wired_i < entries_i at acceptance, every result lies between wired_i and entries_i - 1 inclusive.
- R5: The state does not change in any cycle without an accepted request, so idle time has no effect on later results.
- R6: A request is accepted on a rising edge where req_i is high and no computation is in progress. idx_vld_o is high for exactly one cycle, starting 16 rising edges after the accepting edge. Requests made while a computation is in progress are ignored: they produce no result and do not advance the state.
- R7: When wired_i >= entries_i at acceptance, the result is entries_i - 1 (taken in 6 bits), and the state still advances.
- R8: entries_i (1 to 64, 7 bits) and wired_i (6 bits) are sampled only on the accepting edge. Changing them during a computation does not alter its result.
- R9: idx_o keeps its last result until the next result is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request for a new replacement slot |
| entries_i | input | 7 | Number of implemented slots, 1 to 64 |
| wired_i | input | 6 | Lower boundary: count of locked slots |
| idx_o | output | 6 | Chosen slot |
| idx_vld_o | output | 1 | One-cycle pulse when idx_o carries a fresh result |

## Verification
The assertions check on every cycle:
- that the state holds unless a request is accepted, including requests made while busy;
- that every valid pulse is a single cycle at the fixed 16-edge latency from its acceptance;
- that each result lies in the window captured at acceptance, or equals the top slot when the window is empty;
- that the output holds between pulses.

Only the bench's scenarios can show that results follow the exact congruential sequence and the exact modulo fold over many slot counts and boundaries. The same holds for the first result after reset, and for values applied to entries_i and wired_i during a computation having no effect.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
  // sequencing phase of the serial remainder unit
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } tlbr_phase_e;
endpackage

// File: rtl/tlbr_lcg.sv
module tlbr_lcg #(
  parameter int ST_W = 32,
  parameter int MUL  = 314159,
  parameter int ADD  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  output logic [ST_W-1:0] state_o,
  output logic [ST_W-1:0] next_o
);
  localparam logic [ST_W-1:0] MUL_C = ST_W'(MUL);
  localparam logic [ST_W-1:0] ADD_C = ST_W'(ADD);

  // one congruential step, wrapping at 2^ST_W
  function automatic logic [ST_W-1:0] lcg_next(input logic [ST_W-1:0] s);
    return s * MUL_C + ADD_C;
  endfunction

  logic [ST_W-1:0] st_q;

  assign next_o  = lcg_next(st_q);
  assign state_o = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (adv_i) st_q <= next_o;
  end
endmodule

// File: rtl/tlbr_remdiv.sv
module tlbr_remdiv
  import tlbr_pkg::*;
#(
  parameter int DVD_W = 16,
  parameter int DVS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(DVD_W - 1);

  // restoring step: shift in one dividend bit, subtract divisor if it fits
  function automatic logic [DVS_W-1:0] rem_shift(input logic [DVS_W-1:0] r,
                                                 input logic b,
                                                 input logic [DVS_W-1:0] d);
    logic [DVS_W:0] t;
    t = {r, b};
    if (t >= {1'b0, d}) t = t - {1'b0, d};
    return t[DVS_W-1:0];
  endfunction

  tlbr_phase_e      ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] dvs_q;
  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] rem_nx;
  logic             last_w;

  assign rem_nx = rem_shift(rem_q, dvd_q[DVD_W-1], dvs_q);
  assign last_w = (ph_q == PH_RUN) && (cnt_q == LAST_C);
  assign busy_o = (ph_q == PH_RUN);
  assign done_o = last_w;
  assign rem_o  = rem_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      ph_q  <= PH_RUN;
      cnt_q <= '0;
      dvd_q <= dvd_i;
      dvs_q <= dvs_i;
      rem_q <= '0;
    end else if (ph_q == PH_RUN) begin
      rem_q <= rem_nx;
      dvd_q <= dvd_q << 1;
      cnt_q <= cnt_q + 1'b1;
      if (last_w) ph_q <= PH_IDLE;
    end
  end
endmodule

// File: rtl/tlbr_fold.sv
module tlbr_fold #(
  parameter int ENT_W = 7,
  parameter int IDX_W = ENT_W - 1
) (
  input  logic [ENT_W-1:0] rem_i,
  input  logic [ENT_W-1:0] ent_i,
  input  logic [IDX_W-1:0] wired_i,
  input  logic             empty_i,
  output logic [IDX_W-1:0] idx_o
);
  // offset the remainder by the locked boundary, or pick the top slot
  function automatic logic [IDX_W-1:0] place(input logic [ENT_W-1:0] r,
                                             input logic [ENT_W-1:0] e,
                                             input logic [IDX_W-1:0] w,
                                             input logic emp);
    logic [ENT_W-1:0] s;
    if (emp) s = e - ENT_W'(1);
    else     s = r + ENT_W'(w);
    return s[IDX_W-1:0];
  endfunction

  assign idx_o = place(rem_i, ent_i, wired_i, empty_i);
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx #(
  parameter int ST_W    = 32,
  parameter int LCG_MUL = 314159,
  parameter int LCG_ADD = 1,
  parameter int ENT_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [ENT_W-1:0] entries_i,
  input  logic [ENT_W-2:0] wired_i,
  output logic [ENT_W-2:0] idx_o,
  output logic             idx_vld_o
);
  localparam int IDX_W = ENT_W - 1;
  localparam int HI_W  = ST_W / 2;

  logic             busy_w;
  logic             start_w;
  logic             done_w;
  logic [ST_W-1:0]  state_w;
  logic [ST_W-1:0]  next_w;
  logic [ENT_W-1:0] span_c;
  logic             empty_c;
  logic [ENT_W-1:0] dvs_c;
  logic [ENT_W-1:0] rem_w;
  logic [IDX_W-1:0] fold_w;

  logic [ENT_W-1:0] ent_q;
  logic [IDX_W-1:0] wir_q;
  logic             empty_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q;

  assign start_w = req_i && !busy_w;
  assign empty_c = ENT_W'(wired_i) >= entries_i;
  assign span_c  = entries_i - ENT_W'(wired_i);
  assign dvs_c   = empty_c ? ENT_W'(1) : span_c;

  tlbr_lcg #(.ST_W(ST_W), .MUL(LCG_MUL), .ADD(LCG_ADD)) u_lcg (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (start_w),
    .state_o (state_w),
    .next_o  (next_w)
  );

  tlbr_remdiv #(.DVD_W(HI_W), .DVS_W(ENT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_w),
    .dvd_i  (next_w[ST_W-1 -: HI_W]),
    .dvs_i  (dvs_c),
    .busy_o (busy_w),
    .done_o (done_w),
    .rem_o  (rem_w)
  );

  tlbr_fold #(.ENT_W(ENT_W), .IDX_W(IDX_W)) u_fold (
    .rem_i   (rem_w),
    .ent_i   (ent_q),
    .wired_i (wir_q),
    .empty_i (empty_q),
    .idx_o   (fold_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q   <= '0;
      wir_q   <= '0;
      empty_q <= 1'b0;
    end else if (start_w) begin
      ent_q   <= entries_i;
      wir_q   <= wired_i;
      empty_q <= empty_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= done_w;
      if (done_w) idx_q <= fold_w;
    end
  end

  assign idx_o     = idx_q;
  assign idx_vld_o = vld_q;
endmodule

// File: rtl/tlbr_chk.sv
module tlbr_chk #(
  parameter int ENT_W = 7,
  parameter int ST_W  = 32,
  parameter int LAT   = ST_W / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic [ENT_W-1:0] entries_i,
  input logic [ENT_W-2:0] wired_i,
  input logic [ENT_W-2:0] idx_o,
  input logic             idx_vld_o,
  input logic             busy,
  input logic             start,
  input logic [ST_W-1:0]  state
);
  localparam int AGE_W = $clog2(LAT + 2);

  logic             pend_q;
  logic [AGE_W-1:0] age_q;
  logic [ENT_W-1:0] ent_c;
  logic [ENT_W-1:0] wir_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      age_q  <= '0;
      ent_c  <= '0;
      wir_c  <= '0;
    end else begin
      if (start) begin
        pend_q <= 1'b1;
        age_q  <= '0;
        ent_c  <= entries_i;
        wir_c  <= ENT_W'(wired_i);
      end else begin
        if (idx_vld_o) pend_q <= 1'b0;
        if (pend_q && age_q <= AGE_W'(LAT)) age_q <= age_q + 1'b1;
      end
    end
  end

  // R5: no accepted request, no state change
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(state));

  // R6: a request while busy leaves the state alone
  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_i) |=> $stable(state));

  // R6: valid appears only for a pending request, at the fixed latency
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_vld_o |-> (pend_q && age_q == AGE_W'(LAT)));

  // R6: valid is a single-cycle pulse
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_vld_o |=> !idx_vld_o);

  // R4: result inside the captured window
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_vld_o && wir_c < ent_c) |->
      (ENT_W'(idx_o) >= wir_c && ENT_W'(idx_o) < ent_c));

  // R7: empty window yields the top slot
  p_empty_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_vld_o && wir_c >= ent_c) |->
      (idx_o == (ENT_W-1)'(ent_c - ENT_W'(1))));

  // R9: output holds between pulses
  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_vld_o |-> $stable(idx_o));
endmodule

bind tlb_rand_idx tlbr_chk #(.ENT_W(ENT_W), .ST_W(ST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .entries_i (entries_i),
  .wired_i   (wired_i),
  .idx_o     (idx_o),
  .idx_vld_o (idx_vld_o),
  .busy      (busy_w),
  .start     (start_w),
  .state     (state_w)
);

// File: tb/tlb_rand_idx_bench.sv
module tlb_rand_idx_bench;
  localparam int LAT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [6:0] entries_i = 7'd64;
  logic [5:0] wired_i = 6'd0;
  logic [5:0] idx_o;
  logic       idx_vld_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  bit [31:0] ref_st = 32'd0;
  logic [5:0] last_idx;

  typedef struct {
    logic [5:0] idx;
    int         due;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tlb_rand_idx u_tlb_rand_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .entries_i (entries_i),
    .wired_i   (wired_i),
    .idx_o     (idx_o),
    .idx_vld_o (idx_vld_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: step the state, then place it in the window
  function automatic logic [5:0] model(input int ent, input int wir);
    bit [31:0] hi;
    ref_st = ref_st * 32'd314159 + 32'd1;
    hi = ref_st >> 16;
    if (wir >= ent) return 6'(ent - 1);
    return 6'((hi % (ent - wir)) + wir);
  endfunction

  // driver: one accepted request, expected item pushed to the scoreboard
  task automatic issue(input int ent, input int wir, input string tag);
    exp_t x;
    @(negedge clk);
    entries_i = 7'(ent);
    wired_i   = 6'(wir);
    req_i     = 1'b1;
    x.idx = model(ent, wir);
    x.due = cyc + LAT + 1;
    x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: compare each pulse with the oldest expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() != 0 && cyc > q[0].due) begin
        e = q.pop_front();
        check(1'b0, {e.tag, " R6 missing pulse"}, cyc, e.due);
      end
      if (idx_vld_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R6 pulse with no accepted request", int'(idx_o), -1);
        end else begin
          e = q.pop_front();
          check(idx_o == e.idx, e.tag, int'(idx_o), int'(e.idx));
          check(cyc == e.due, "R6 latency", cyc, e.due);
          last_idx = idx_o;
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(idx_o == 6'd0, "R2 idx after reset", int'(idx_o), 0);
    check(idx_vld_o == 1'b0, "R2 valid after reset", int'(idx_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: first result from state 1, upper half zero, so result equals boundary
    issue(40, 9, "R2 first result");
    drain();

    // R1 R3 R4: sequence across several windows
    for (int i = 0; i < 24; i++) begin
      issue(1 + (i * 11) % 64, (i * 5) % 20, "R1 R3 sequence");
      drain();
    end
    issue(64, 0, "R4 full window");
    drain();
    issue(64, 63, "R4 single-slot window");
    drain();
    issue(1, 0, "R4 one slot");
    drain();

    // R5: long idle, state must not move
    repeat (50) @(negedge clk);
    issue(33, 2, "R5 after idle");
    drain();

    // R9: output holds after the pulse
    repeat (6) @(negedge clk);
    check(idx_o == last_idx, "R9 idx holds", int'(idx_o), int'(last_idx));

    // R7: empty window
    issue(10, 10, "R7 equal bound");
    drain();
    issue(5, 40, "R7 bound above count");
    drain();
    issue(20, 3, "R7 state advanced");
    drain();

    // R6 R8: busy requests ignored, inputs changed mid-flight
    issue(50, 7, "R8 inputs sampled at accept");
    repeat (3) @(negedge clk);
    entries_i = 7'd3;
    wired_i   = 6'd1;
    req_i     = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (5) @(negedge clk);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    issue(50, 7, "R6 state not advanced by busy request");
    drain();

    // R6: back-to-back held request accepted only when idle
    @(negedge clk);
    entries_i = 7'd30;
    wired_i   = 6'd4;
    req_i     = 1'b1;
    e.idx = model(30, 4);
    e.due = cyc + LAT + 1;
    e.tag = "R6 held request first";
    q.push_back(e);
    repeat (LAT + 1) @(negedge clk);
    e.idx = model(30, 4);
    e.due = cyc + LAT + 1;
    e.tag = "R6 held request second";
    q.push_back(e);
    @(negedge clk);
    req_i = 1'b0;
    drain();

    repeat (25) @(negedge clk);
    summary();
  end
endmodule